// File: doc/BRIEF.md
# Multi-Line Page Write Cache

This block sits between a serial slave front end and a non-volatile storage array. While a write transaction is in progress it collects data bytes into a 64-byte cache, organised as eight lines of eight bytes. Each cache line stands for one eight-byte page of the array. Nothing reaches the array while bytes are still arriving. When the transaction ends with a STOP, the block walks through the lines that hold data and hands them to the array one line at a time. Each line is given a fixed self-timed write window.

The front end sends four kinds of event. `wrStart` carries the 13-bit start address once the address phase of a write is complete. `byteValid` strobes one data byte. `stopEvt` marks the end of the transaction. `busStart` reports any START condition on the bus. While the commit runs, `busy` stays high so that the front end withholds acknowledges. The busy time grows in proportion to the number of lines that were loaded.

Top module: `line_write_cache`

## Requirements
- R1: After reset, `busy` and `commitValid` are both 0.
- R2: The write pointer is the low 6 address bits. Bits [2:0] select the byte lane and bits [5:3] select the cache line. The pointer starts at `startAddr[5:0]` and steps by one after every accepted byte. A step from lane 7 moves to lane 0 of the next line, and a step from line 7 moves to line 0. `startAddr[12:6]` stays fixed for the whole transaction.
- R3: When more than 64 bytes arrive before STOP, the pointer wraps. Byte number k+64 overwrites the cache slot of byte number k.
- R4: No commit happens before STOP. A STOP that arrives while bytes are loaded raises `busy` in the next cycle. The first commit is issued in that same first busy cycle.
- R5: Lines are committed in ascending line order, one line per `commitValid` pulse. `commitPage` is `{startAddr[12:6], line}`. Byte lane k is carried on `commitData[8k+7:8k]`, and its presence is flagged on `commitMask[k]`.
- R6: Consecutive commits are exactly PAGE_CYCLES cycles apart. `busy` stays high for exactly (lines loaded) x PAGE_CYCLES cycles.
- R7: Only bytes actually received have their mask bit set. A line that received no byte is skipped and costs no time.
- R8: A write of a single data byte produces exactly one commit and PAGE_CYCLES busy cycles.
- R9: A `busStart` during loading discards all captured bytes, and a later STOP commits nothing. A new `wrStart` during loading also discards the earlier bytes before it reloads the pointer.
- R10: While `busy` is high, `wrStart`, `byteValid`, `busStart` and `stopEvt` have no effect. The data, order, timing and length of the running commit stay unchanged.
- R11: A STOP that follows a `wrStart` with no data bytes commits nothing and leaves `busy` low. A STOP in the idle state does the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrStart | input | 1 | Write address phase complete, load pointer |
| startAddr | input | 13 | Start address of the write, valid with `wrStart` |
| byteValid | input | 1 | One data byte is present on `byteData` |
| byteData | input | 8 | Received data byte |
| stopEvt | input | 1 | STOP seen on the bus |
| busStart | input | 1 | START seen on the bus |
| busy | output | 1 | Self-timed write in progress |
| commitValid | output | 1 | Single-cycle pulse: one line handed to the array |
| commitPage | output | 10 | Array page number of the committed line |
| commitData | output | 64 | Line data, lane k in bits 8k+7:8k |
| commitMask | output | 8 | Per-lane written flags of the committed line |

## Verification
The bench aims at the places where the pointer arithmetic can go wrong. The first case starts in the middle of a line, so a design that reset the lane on a line change would write into the wrong lanes. The second crosses from line 7 back to line 0, where a design that carried into the upper address would commit the wrong page number. The third writes 70 bytes, where a design that stopped at 64 would keep the stale bytes instead of the newer ones. Aborted and address-only transactions check that a design which committed leftover bytes would raise `busy` spuriously. The injected events during a commit check that a design which listened to them would corrupt pending lines or shift the commit timing.

// File: rtl/lwc_pkg.sv
`timescale 1ns/1ps
package lwc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_WRITE = 2'd2
  } lwc_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clr;       // drop every captured byte
    logic loadAddr;  // take a new start address
    logic wrByte;    // store byteData at the pointer and step it
    logic issue;     // present one line to the array this cycle
  } lwc_strobe_t;
endpackage

// File: rtl/lwc_datapath.sv
`timescale 1ns/1ps
module lwc_datapath
  import lwc_pkg::*;
#(
  parameter int LINES      = 8,
  parameter int LINE_BYTES = 8,
  parameter int ADDR_W     = 13
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  lwc_strobe_t                            strb,
  input  logic [ADDR_W-1:0]                      startAddr,
  input  logic [7:0]                             byteData,
  input  logic [$clog2(LINES)-1:0]               issueLine,
  output logic [LINES-1:0]                       lineValid,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   commitPage,
  output logic [LINE_BYTES*8-1:0]                commitData,
  output logic [LINE_BYTES-1:0]                  commitMask
);
  localparam int BYTE_W = $clog2(LINE_BYTES);
  localparam int LINE_W = $clog2(LINES);
  localparam int PTR_W  = BYTE_W + LINE_W;
  localparam int BASE_W = ADDR_W - PTR_W;
  localparam int DATA_W = LINE_BYTES * 8;

  logic [PTR_W-1:0]  ptr;
  logic [BASE_W-1:0] base;
  logic [LINE_W-1:0] wrLine;
  logic [BYTE_W-1:0] wrLane;

  logic [DATA_W-1:0]     dataView [LINES];
  logic [LINE_BYTES-1:0] maskView [LINES];

  assign wrLine = ptr[PTR_W-1:BYTE_W];
  assign wrLane = ptr[BYTE_W-1:0];

  // Pointer and fixed upper address
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr  <= '0;
      base <= '0;
    end else if (strb.loadAddr) begin
      ptr  <= startAddr[PTR_W-1:0];
      base <= startAddr[ADDR_W-1:PTR_W];
    end else if (strb.wrByte) begin
      ptr  <= ptr + 1'b1;
    end
  end

  // One storage line per cache line
  for (genvar L = 0; L < LINES; L++) begin : g_line
    logic [DATA_W-1:0]     lineData;
    logic [LINE_BYTES-1:0] maskReg;
    logic                  hitLine;

    assign hitLine = strb.wrByte && (wrLine == LINE_W'(L));

    always_ff @(posedge clk) begin
      if (hitLine) lineData[wrLane*8 +: 8] <= byteData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             maskReg <= '0;
      else if (strb.clr)     maskReg <= '0;
      else if (hitLine)      maskReg[wrLane] <= 1'b1;
    end

    assign dataView[L]  = lineData;
    assign maskView[L]  = maskReg;
    assign lineValid[L] = |maskReg;
  end

  assign commitData = dataView[issueLine];
  assign commitMask = maskView[issueLine];
  assign commitPage = {base, issueLine};

  // R2: every stored byte advances the pointer by exactly one
  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrByte && !strb.loadAddr) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

  // R2: upper address bits only change on a new start address
  p_base_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadAddr |=> (base == $past(base)));

  // R9: a clear leaves no line marked as loaded
  p_clear_empty_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clr && !strb.wrByte) |=> (lineValid == '0));
endmodule

// File: rtl/lwc_control.sv
`timescale 1ns/1ps
module lwc_control
  import lwc_pkg::*;
#(
  parameter int LINES       = 8,
  parameter int PAGE_CYCLES = 20
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrStart,
  input  logic                       busStart,
  input  logic                       byteValid,
  input  logic                       stopEvt,
  input  logic [LINES-1:0]           lineValid,
  output lwc_strobe_t                strb,
  output logic [$clog2(LINES)-1:0]   issueLine,
  output logic                       busy
);
  localparam int LINE_W = $clog2(LINES);
  localparam int TMR_W  = $clog2(PAGE_CYCLES + 1);

  lwc_state_e        state, stateN;
  logic [LINES-1:0]  pend, pendN;
  logic [TMR_W-1:0]  timer, timerN;
  logic [LINE_W-1:0] pick;

  // Lowest pending line
  always_comb begin
    pick = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (pend[i]) pick = LINE_W'(i);
    end
  end

  always_comb begin
    strb   = '0;
    stateN = state;
    pendN  = pend;
    timerN = timer;
    unique case (state)
      ST_IDLE: begin
        if (wrStart) begin
          strb.clr      = 1'b1;
          strb.loadAddr = 1'b1;
          stateN        = ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (stopEvt) begin
          if (|lineValid) begin
            stateN = ST_WRITE;
            pendN  = lineValid;
            timerN = '0;
          end else begin
            stateN = ST_IDLE;
          end
        end else if (busStart) begin
          strb.clr = 1'b1;
          stateN   = ST_IDLE;
        end else if (wrStart) begin
          strb.clr      = 1'b1;
          strb.loadAddr = 1'b1;
        end else if (byteValid) begin
          strb.wrByte = 1'b1;
        end
      end
      ST_WRITE: begin
        if (timer == '0) begin
          strb.issue = 1'b1;
          pendN      = pend & ~(LINES'(1) << pick);
          timerN     = TMR_W'(PAGE_CYCLES - 1);
        end else begin
          timerN = timer - 1'b1;
        end
        if ((timerN == '0) && (pendN == '0)) stateN = ST_IDLE;
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      pend  <= '0;
      timer <= '0;
    end else begin
      state <= stateN;
      pend  <= pendN;
      timer <= timerN;
    end
  end

  assign issueLine = pick;
  assign busy      = (state == ST_WRITE);

  // R4: a STOP with loaded bytes starts the self-timed write next cycle
  p_stop_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD && stopEvt && (|lineValid)) |=> busy);

  // R6: two commits are never in adjacent cycles when the window is longer than one
  p_issue_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issue && (PAGE_CYCLES > 1)) |=> !strb.issue);

  // R7: a line is only issued while it is still pending
  p_issue_pending_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |=> !pend[$past(pick)]);
endmodule

// File: rtl/line_write_cache.sv
`timescale 1ns/1ps
module line_write_cache
  import lwc_pkg::*;
#(
  parameter int LINES       = 8,
  parameter int LINE_BYTES  = 8,
  parameter int ADDR_W      = 13,
  parameter int PAGE_CYCLES = 20
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 wrStart,
  input  logic [ADDR_W-1:0]                    startAddr,
  input  logic                                 byteValid,
  input  logic [7:0]                           byteData,
  input  logic                                 stopEvt,
  input  logic                                 busStart,
  output logic                                 busy,
  output logic                                 commitValid,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] commitPage,
  output logic [LINE_BYTES*8-1:0]              commitData,
  output logic [LINE_BYTES-1:0]                commitMask
);
  localparam int LINE_W = $clog2(LINES);

  lwc_strobe_t       strb;
  logic [LINE_W-1:0] issueLine;
  logic [LINES-1:0]  lineValid;

  lwc_control #(.LINES(LINES), .PAGE_CYCLES(PAGE_CYCLES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrStart   (wrStart),
    .busStart  (busStart),
    .byteValid (byteValid),
    .stopEvt   (stopEvt),
    .lineValid (lineValid),
    .strb      (strb),
    .issueLine (issueLine),
    .busy      (busy)
  );

  lwc_datapath #(.LINES(LINES), .LINE_BYTES(LINE_BYTES), .ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .startAddr  (startAddr),
    .byteData   (byteData),
    .issueLine  (issueLine),
    .lineValid  (lineValid),
    .commitPage (commitPage),
    .commitData (commitData),
    .commitMask (commitMask)
  );

  assign commitValid = strb.issue;

  // R7: every committed line carries at least one received byte
  p_commit_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |-> (commitMask != '0));

  // R10: the cache contents cannot change while the write runs
  p_frozen_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strb.wrByte || strb.clr || strb.loadAddr));
endmodule

// File: tb/tb_line_write_cache.sv
`timescale 1ns/1ps
module tb_line_write_cache;
  localparam int P = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStart = 1'b0;
  logic [12:0] startAddr = '0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        stopEvt = 1'b0;
  logic        busStart = 1'b0;
  logic        busy;
  logic        commitValid;
  logic [9:0]  commitPage;
  logic [63:0] commitData;
  logic [7:0]  commitMask;

  line_write_cache #(.PAGE_CYCLES(P)) dut (
    .clk(clk), .rstN(rstN), .wrStart(wrStart), .startAddr(startAddr),
    .byteValid(byteValid), .byteData(byteData), .stopEvt(stopEvt),
    .busStart(busStart), .busy(busy), .commitValid(commitValid),
    .commitPage(commitPage), .commitData(commitData), .commitMask(commitMask)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;
  int cyc     = 0;
  int stopCyc = 0;

  // Reference model of the cache
  logic [7:0] mMem  [64];
  bit         mMask [64];
  logic [6:0] mBase;
  int         mPtr;

  // Recorded commits
  int          nRec = 0;
  int          busyCnt = 0;
  logic [9:0]  rPage [16];
  logic [63:0] rData [16];
  logic [7:0]  rMask [16];
  int          rCyc  [16];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN) begin
      if (busy) busyCnt++;
      if (commitValid && nRec < 16) begin
        rPage[nRec] = commitPage;
        rData[nRec] = commitData;
        rMask[nRec] = commitMask;
        rCyc[nRec]  = cyc;
        nRec++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clearMon();
    nRec = 0;
    busyCnt = 0;
  endtask

  task automatic doWrStart(input logic [12:0] a, input bit upd);
    @(negedge clk);
    wrStart = 1'b1; startAddr = a;
    @(negedge clk);
    wrStart = 1'b0;
    if (upd) begin
      for (int i = 0; i < 64; i++) mMask[i] = 0;
      mPtr  = int'(a[5:0]);
      mBase = a[12:6];
    end
  endtask

  task automatic doByte(input logic [7:0] b, input bit upd);
    @(negedge clk);
    byteValid = 1'b1; byteData = b;
    @(negedge clk);
    byteValid = 1'b0;
    if (upd) begin
      mMem[mPtr]  = b;
      mMask[mPtr] = 1;
      mPtr = (mPtr + 1) % 64;
    end
  endtask

  task automatic doBusStart(input bit upd);
    @(negedge clk);
    busStart = 1'b1;
    @(negedge clk);
    busStart = 1'b0;
    if (upd) for (int i = 0; i < 64; i++) mMask[i] = 0;
  endtask

  task automatic doStop(input bit mark);
    @(negedge clk);
    stopEvt = 1'b1;
    if (mark) stopCyc = cyc;
    @(negedge clk);
    stopEvt = 1'b0;
  endtask

  task automatic waitIdle();
    int guard = 0;
    repeat (2) @(negedge clk);
    while (busy && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  // Compare recorded commits against the model
  task automatic checkCommits(input string req);
    int nExp = 0;
    waitIdle();
    for (int ln = 0; ln < 8; ln++) begin
      logic [7:0]  eMask = '0;
      logic [63:0] eData = '0;
      logic [63:0] lanes = '0;
      for (int k = 0; k < 8; k++) begin
        if (mMask[ln*8+k]) begin
          eMask[k] = 1'b1;
          eData[k*8 +: 8] = mMem[ln*8+k];
          lanes[k*8 +: 8] = 8'hFF;
        end
      end
      if (eMask != 0) begin
        if (nExp < nRec) begin
          chk(rPage[nExp] == {mBase, 3'(ln)}, req, "page", 64'(rPage[nExp]), 64'({mBase, 3'(ln)}));
          chk(rMask[nExp] == eMask, req, "mask", 64'(rMask[nExp]), 64'(eMask));
          chk((rData[nExp] & lanes) == eData, req, "data", rData[nExp] & lanes, eData);
          chk(rCyc[nExp] == stopCyc + 1 + nExp * P, req, "commit cycle",
              64'(rCyc[nExp]), 64'(stopCyc + 1 + nExp * P));
        end
        nExp++;
      end
    end
    chk(nRec == nExp, req, "commit count", 64'(nRec), 64'(nExp));
    chk(busyCnt == nExp * P, req, "busy cycles", 64'(busyCnt), 64'(nExp * P));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", 64'(busy), 64'd0);
    chk(commitValid == 1'b0, "R1", "commitValid after reset", 64'(commitValid), 64'd0);
  endtask

  task automatic t_single();  // R8, R5, R6
    clearMon();
    doWrStart(13'h1234, 1);
    doByte(8'hA7, 1);
    doStop(1);
    checkCommits("R8");
  endtask

  task automatic t_midline();  // R2, R7: start in lane 5, spill into next line
    clearMon();
    doWrStart(13'h00A5, 1);
    for (int i = 0; i < 8; i++) doByte(8'(8'h30 + i), 1);
    repeat (3) @(negedge clk);
    chk(nRec == 0 && busy == 1'b0, "R4", "commit before stop", 64'(nRec), 64'd0);
    doStop(1);
    checkCommits("R2");
  endtask

  task automatic t_linewrap();  // R2: line 7 rolls to line 0 of the same block
    clearMon();
    doWrStart(13'h1F3C, 1);
    for (int i = 0; i < 10; i++) doByte(8'(8'hC0 + i), 1);
    doStop(1);
    checkCommits("R2");
    chk(nRec == 2 && rPage[0] == 10'h3E0, "R5", "ascending order first page",
        64'(rPage[0]), 64'h3E0);
  endtask

  task automatic t_overflow();  // R3, R6: 70 bytes, all lines
    clearMon();
    doWrStart(13'h0800, 1);
    for (int i = 0; i < 70; i++) doByte(8'(i * 7 + 1), 1);
    doStop(1);
    checkCommits("R3");
    chk(rData[0][7:0] == 8'(64 * 7 + 1), "R3", "overwritten byte 0",
        64'(rData[0][7:0]), 64'(8'(64 * 7 + 1)));
  endtask

  task automatic t_abort();  // R9
    clearMon();
    doWrStart(13'h0100, 1);
    for (int i = 0; i < 5; i++) doByte(8'(8'h55 + i), 1);
    doBusStart(1);
    doStop(1);
    waitIdle();
    chk(nRec == 0, "R9", "commits after abort", 64'(nRec), 64'd0);
    chk(busyCnt == 0, "R9", "busy after abort", 64'(busyCnt), 64'd0);
    clearMon();
    doWrStart(13'h0200, 1);
    for (int i = 0; i < 4; i++) doByte(8'(8'h11 + i), 1);
    doWrStart(13'h0310, 1);
    for (int i = 0; i < 3; i++) doByte(8'(8'h91 + i), 1);
    doStop(1);
    checkCommits("R9");
  endtask

  task automatic t_addrOnly();  // R11
    clearMon();
    doWrStart(13'h0040, 1);
    doStop(1);
    waitIdle();
    chk(nRec == 0 && busyCnt == 0, "R11", "address-only stop", 64'(nRec + busyCnt), 64'd0);
    clearMon();
    doStop(1);
    waitIdle();
    chk(nRec == 0 && busyCnt == 0, "R11", "idle stop", 64'(nRec + busyCnt), 64'd0);
  endtask

  task automatic t_ignoreBusy();  // R10
    clearMon();
    doWrStart(13'h0A08, 1);
    for (int i = 0; i < 16; i++) doByte(8'(8'hE0 + i), 1);
    doStop(1);
    doBusStart(0);
    doWrStart(13'h0A10, 0);
    for (int i = 0; i < 3; i++) doByte(8'hFF, 0);
    doStop(0);
    checkCommits("R10");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_single();
    t_midline();
    t_linewrap();
    t_overflow();
    t_abort();
    t_addrOnly();
    t_ignoreBusy();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end
endmodule